// File: doc/BRIEF.md
# DRAM Bank Command Spacing Tracker

This block watches the commands a memory scheduler issues to one bank group and tells the scheduler, one cycle at a time, which kinds of command it may issue next. Five minimum spacings are tracked at once. Each spacing has its own programmable length in memory clock cycles, with one-clock resolution: activate to activate, activate to precharge, activate to read or write, precharge to activate or refresh, and refresh to activate.

Each spacing has a down-counter. The counter is loaded when the command that starts the spacing is issued, and it runs down to zero. The four permission outputs are combinations of the counters that have reached zero. The scheduler samples a permission in a cycle, and if the permission is high it may issue that command in the same cycle. The spacing lengths are inputs. Each one is read only in the cycle in which its counter is loaded, so software may change it while a count is running without affecting that count.

Top module: `dram_bank_gap_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four permission outputs are high.
- R2: An activate issued in cycle t holds `may_act_o` low in cycles t+1 to t+N-1, where N is `gap_act_act_i` sampled in cycle t.
- R3: An activate issued in cycle t holds `may_pre_o` low in cycles t+1 to t+N-1, where N is `gap_act_pre_i` sampled in cycle t.
- R4: An activate issued in cycle t holds `may_rw_o` low in cycles t+1 to t+N-1, where N is `gap_act_rw_i` sampled in cycle t.
- R5: A precharge issued in cycle t holds both `may_act_o` and `may_ref_o` low in cycles t+1 to t+N-1, where N is `gap_pre_act_i` sampled in cycle t.
- R6: A refresh issued in cycle t holds `may_act_o` low in cycles t+1 to t+N-1, where N is `gap_ref_act_i` sampled in cycle t.
- R7: A spacing length of 0 or 1 blocks nothing. The command it gates is permitted again in cycle t+1.
- R8: `may_act_o` is high exactly when the activate-to-activate, precharge-to-activate and refresh-to-activate windows have all expired. `may_rw_o`, `may_pre_o` and `may_ref_o` each depend only on their own single window. Once a permission is high, it stays high until a command that starts one of its windows is issued.
- R9: A spacing length that changes while its window is running does not move the end of that window.
- R10: If the starting command of a window is issued again while the window is still running, the window restarts from the new command, using the spacing length sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_act_i | input | 1 | Activate issued this cycle |
| cmd_pre_i | input | 1 | Precharge issued this cycle |
| cmd_ref_i | input | 1 | Refresh issued this cycle |
| gap_act_act_i | input | W | Activate-to-activate spacing, cycles |
| gap_act_pre_i | input | W | Activate-to-precharge spacing, cycles |
| gap_act_rw_i | input | W | Activate-to-read/write spacing, cycles |
| gap_pre_act_i | input | W | Precharge-to-activate/refresh spacing, cycles |
| gap_ref_act_i | input | W | Refresh-to-activate spacing, cycles |
| may_act_o | output | 1 | Activate permitted |
| may_rw_o | output | 1 | Read or write permitted |
| may_pre_o | output | 1 | Precharge permitted |
| may_ref_o | output | 1 | Refresh permitted |

## Verification
The bench builds the tracker with a spacing width of 4 bits, so every length from 0 to the maximum of 15 is reachable. With this width, a random phase also reaches full-length windows, reloads that overlap running windows, and several commands that start in the same cycle. Directed sequences cover the lengths 0 and 1, a length that changes while its window is running, and a restart part-way through a window. A behavioural model of the remaining cycles in each window is compared with all four permissions on every clock.

// File: rtl/dram_gap_pkg.sv
package dram_gap_pkg;
  localparam int NUM_GAPS = 5;
  localparam int G_ACT_ACT = 0;
  localparam int G_ACT_PRE = 1;
  localparam int G_ACT_RW  = 2;
  localparam int G_PRE_ACT = 3;
  localparam int G_REF_ACT = 4;
endpackage

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] span_i,
  output logic         expired_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // Next-state logic. A new load replaces any count that is running.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = (span_i == ZERO) ? ZERO : span_i - ONE;
    end else if (cnt_q != ZERO) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == ZERO);
endmodule

// File: rtl/gap_permit.sv
module gap_permit
  import dram_gap_pkg::*;
(
  input  logic [NUM_GAPS-1:0] expired_i,
  output logic                may_act_o,
  output logic                may_rw_o,
  output logic                may_pre_o,
  output logic                may_ref_o
);
  always_comb begin
    may_act_o = expired_i[G_ACT_ACT] & expired_i[G_PRE_ACT] & expired_i[G_REF_ACT];
    may_rw_o  = expired_i[G_ACT_RW];
    may_pre_o = expired_i[G_ACT_PRE];
    may_ref_o = expired_i[G_PRE_ACT];
  end
endmodule

// File: rtl/dram_bank_gap_tracker.sv
module dram_bank_gap_tracker
  import dram_gap_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_act_i,
  input  logic         cmd_pre_i,
  input  logic         cmd_ref_i,
  input  logic [W-1:0] gap_act_act_i,
  input  logic [W-1:0] gap_act_pre_i,
  input  logic [W-1:0] gap_act_rw_i,
  input  logic [W-1:0] gap_pre_act_i,
  input  logic [W-1:0] gap_ref_act_i,
  output logic         may_act_o,
  output logic         may_rw_o,
  output logic         may_pre_o,
  output logic         may_ref_o
);
  logic [NUM_GAPS-1:0] load;
  logic [W-1:0]        span [NUM_GAPS];
  logic [NUM_GAPS-1:0] expired;

  // Which command starts each window, and which length it uses.
  always_comb begin
    load[G_ACT_ACT] = cmd_act_i;
    load[G_ACT_PRE] = cmd_act_i;
    load[G_ACT_RW]  = cmd_act_i;
    load[G_PRE_ACT] = cmd_pre_i;
    load[G_REF_ACT] = cmd_ref_i;
    span[G_ACT_ACT] = gap_act_act_i;
    span[G_ACT_PRE] = gap_act_pre_i;
    span[G_ACT_RW]  = gap_act_rw_i;
    span[G_PRE_ACT] = gap_pre_act_i;
    span[G_REF_ACT] = gap_ref_act_i;
  end

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_win
    gap_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (load[g]),
      .span_i   (span[g]),
      .expired_o(expired[g])
    );
  end

  gap_permit u_permit (
    .expired_i(expired),
    .may_act_o(may_act_o),
    .may_rw_o (may_rw_o),
    .may_pre_o(may_pre_o),
    .may_ref_o(may_ref_o)
  );
endmodule

// File: rtl/dram_gap_checker.sv
module dram_gap_checker #(
  parameter int W = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_act_i,
  input logic         cmd_pre_i,
  input logic         cmd_ref_i,
  input logic [W-1:0] gap_act_act_i,
  input logic [W-1:0] gap_act_pre_i,
  input logic [W-1:0] gap_act_rw_i,
  input logic [W-1:0] gap_pre_act_i,
  input logic [W-1:0] gap_ref_act_i,
  input logic         may_act_o,
  input logic         may_rw_o,
  input logic         may_pre_o,
  input logic         may_ref_o
);
  localparam logic [W-1:0] TWO = W'(2);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    if (!rst_n) begin
      a_rst_open_r1: assert (may_act_o && may_rw_o && may_pre_o && may_ref_o);
    end
  end

  p_act_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act_i && gap_act_act_i >= TWO) |=> !may_act_o);

  p_act_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act_i && gap_act_pre_i >= TWO) |=> !may_pre_o);

  p_act_rw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act_i && gap_act_rw_i >= TWO) |=> !may_rw_o);

  p_pre_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre_i && gap_pre_act_i >= TWO) |=> (!may_act_o && !may_ref_o));

  p_ref_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ref_i && gap_ref_act_i >= TWO) |=> !may_act_o);

  p_short_rw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act_i && gap_act_rw_i <= ONE) |=> may_rw_o);

  p_short_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre_i && gap_pre_act_i <= ONE) |=> may_ref_o);

  p_rw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (may_rw_o && !cmd_act_i) |=> may_rw_o);

  p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (may_act_o && !cmd_act_i && !cmd_pre_i && !cmd_ref_i) |=> may_act_o);

  p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (may_ref_o && !cmd_pre_i) |=> may_ref_o);
endmodule

bind dram_bank_gap_tracker dram_gap_checker #(.W(W)) u_gap_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_act_i(cmd_act_i), .cmd_pre_i(cmd_pre_i), .cmd_ref_i(cmd_ref_i),
  .gap_act_act_i(gap_act_act_i), .gap_act_pre_i(gap_act_pre_i),
  .gap_act_rw_i(gap_act_rw_i), .gap_pre_act_i(gap_pre_act_i),
  .gap_ref_act_i(gap_ref_act_i),
  .may_act_o(may_act_o), .may_rw_o(may_rw_o),
  .may_pre_o(may_pre_o), .may_ref_o(may_ref_o)
);

// File: tb/tb_dram_bank_gap_tracker.sv
module tb_dram_bank_gap_tracker;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act = 1'b0, pre = 1'b0, rf = 1'b0;
  logic [W-1:0] g_aa = '0, g_ap = '0, g_ar = '0, g_pa = '0, g_ra = '0;
  logic may_act, may_rw, may_pre, may_ref;

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  int rem_aa = 0, rem_ap = 0, rem_ar = 0, rem_pa = 0, rem_ra = 0;

  always #5 clk = ~clk;

  dram_bank_gap_tracker #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_act_i(act), .cmd_pre_i(pre), .cmd_ref_i(rf),
    .gap_act_act_i(g_aa), .gap_act_pre_i(g_ap), .gap_act_rw_i(g_ar),
    .gap_pre_act_i(g_pa), .gap_ref_act_i(g_ra),
    .may_act_o(may_act), .may_rw_o(may_rw), .may_pre_o(may_pre), .may_ref_o(may_ref)
  );

  function automatic int span_left(int len);
    return (len <= 1) ? 0 : len - 1;
  endfunction

  // Behavioural model: cycles remaining in each window.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_aa <= 0; rem_ap <= 0; rem_ar <= 0; rem_pa <= 0; rem_ra <= 0;
    end else begin
      rem_aa <= act ? span_left(int'(g_aa)) : (rem_aa > 0 ? rem_aa - 1 : 0);
      rem_ap <= act ? span_left(int'(g_ap)) : (rem_ap > 0 ? rem_ap - 1 : 0);
      rem_ar <= act ? span_left(int'(g_ar)) : (rem_ar > 0 ? rem_ar - 1 : 0);
      rem_pa <= pre ? span_left(int'(g_pa)) : (rem_pa > 0 ? rem_pa - 1 : 0);
      rem_ra <= rf  ? span_left(int'(g_ra)) : (rem_ra > 0 ? rem_ra - 1 : 0);
    end
  end

  task automatic chk(input logic actual, input logic exp, input string tag);
    n_checks++;
    if (actual !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, actual, exp, $time);
    end
  endtask

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(may_act, (rem_aa == 0) && (rem_pa == 0) && (rem_ra == 0), "R8 model may_act");
      chk(may_rw,  rem_ar == 0, "R4 model may_rw");
      chk(may_pre, rem_ap == 0, "R3 model may_pre");
      chk(may_ref, rem_pa == 0, "R5 model may_ref");
    end
  end

  // Issue a command on the next edge; returns at the negedge one cycle after it (k=1).
  task automatic issue(input logic a, input logic p, input logic r);
    @(negedge clk);
    act = a; pre = p; rf = r;
    @(negedge clk);
    act = 1'b0; pre = 1'b0; rf = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run_main();
    // R1: reset state
    #1;
    chk(may_act & may_rw & may_pre & may_ref, 1'b1, "R1 during reset");
    g_aa = 4'd3; g_ap = 4'd5; g_ar = 4'd2; g_pa = 4'd4; g_ra = 4'd6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(may_act & may_rw & may_pre & may_ref, 1'b1, "R1 after release");
    cmp_on = 1'b1;

    // R2/R3/R4: activate windows
    issue(1, 0, 0);
    chk(may_act, 1'b0, "R2 k1"); chk(may_pre, 1'b0, "R3 k1"); chk(may_rw, 1'b0, "R4 k1");
    step(); chk(may_rw, 1'b1, "R4 k2"); chk(may_act, 1'b0, "R2 k2");
    step(); chk(may_act, 1'b1, "R2 k3"); chk(may_pre, 1'b0, "R3 k3");
    step(); chk(may_pre, 1'b0, "R3 k4");
    step(); chk(may_pre, 1'b1, "R3 k5");

    // R5: precharge blocks activate and refresh
    issue(0, 1, 0);
    chk(may_act, 1'b0, "R5 act k1"); chk(may_ref, 1'b0, "R5 ref k1");
    step(); step(); chk(may_ref, 1'b0, "R5 ref k3");
    step(); chk(may_ref, 1'b1, "R5 ref k4"); chk(may_act, 1'b1, "R5 act k4");

    // R6: refresh recovery
    issue(0, 0, 1);
    chk(may_act, 1'b0, "R6 k1"); chk(may_ref, 1'b1, "R8 ref unaffected by refresh");
    for (int k = 2; k <= 5; k++) step();
    chk(may_act, 1'b0, "R6 k5");
    step(); chk(may_act, 1'b1, "R6 k6");

    // R7: lengths 0 and 1
    g_aa = 4'd1; g_ar = 4'd0; g_ap = 4'd1; g_pa = 4'd0;
    issue(1, 0, 0);
    chk(may_act, 1'b1, "R7 act len1"); chk(may_rw, 1'b1, "R7 rw len0");
    chk(may_pre, 1'b1, "R7 pre len1");
    issue(0, 1, 0);
    chk(may_ref, 1'b1, "R7 ref len0");

    // R9: length change mid-window
    g_ar = 4'd6;
    issue(1, 0, 0);
    g_ar = 4'd1;
    for (int k = 2; k <= 5; k++) step();
    chk(may_rw, 1'b0, "R9 k5 still blocked");
    step(); chk(may_rw, 1'b1, "R9 k6 open");

    // R10: restart while running
    g_ar = 4'd4;
    issue(1, 0, 0);
    step();
    issue(1, 0, 0);
    step(); chk(may_rw, 1'b0, "R10 restart k2");
    step(); chk(may_rw, 1'b0, "R10 restart k3");
    step(); chk(may_rw, 1'b1, "R10 restart k4");

    // Random phase, model compared every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      act = ($urandom_range(0, 5) == 0);
      pre = ($urandom_range(0, 6) == 0);
      rf  = ($urandom_range(0, 9) == 0);
      g_aa = W'($urandom); g_ap = W'($urandom); g_ar = W'($urandom);
      g_pa = W'($urandom); g_ra = W'($urandom);
    end
    @(negedge clk);
    act = 1'b0; pre = 1'b0; rf = 1'b0;
    repeat (20) @(negedge clk);
    chk(may_act & may_rw & may_pre & may_ref, 1'b1, "R8 all open when idle");
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
      end
    join_any
    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule